// File: doc/BRIEF.md
# Gaussian Mean-Shift Point Mover

This block walks a single feature-space point toward the nearest density peak of a grayscale image. A point has three features: its column, its row and its intensity. After a start pulse loads the initial point, the block runs a sequence of passes. In each pass the entire original image streams in, one reference pixel per clock. For every reference pixel the block forms the squared three-dimensional distance to the current point, with no square root. It turns that distance into a Gaussian weight through a lookup table and adds the weight, and the weight times each coordinate, into four accumulators.

When the pass ends, a divider that belongs only to this block computes each coordinate's weighted mean. That mean becomes the point for the next pass. The reference image itself is never modified. The block stops when every coordinate has moved by no more than a programmable threshold, or when it has completed a programmed number of passes. It then pulses done and holds the final location. All arithmetic is unsigned fixed point. The intended use is as one lane in a wide array, where many such blocks share a single broadcast image stream.

The reference stream uses valid/ready. The block raises `ref_ready` only while a pass is open, and a pixel transfers on any cycle where both `ref_valid` and `ref_ready` are high. During a pass the block never applies back-pressure. The source may insert idle cycles by lowering `ref_valid`. The pixel marked with `ref_last` closes the pass. `ref_ready` then stays low until the next pass opens, which happens after the pipeline drains and the division finishes. Start, threshold, pass limit, busy, done and converged are plain level or pulse pins.

Top module: `ms_point_mover`

## Requirements
- R1: After reset, `busy`, `done`, `ref_ready` and `converged` are low, and the result location reads (0,0,0).
- R2: `ref_ready` is high for every cycle of an open pass, whether the source presents pixels back to back or with idle cycles between them. It drops on the cycle after the pixel with `ref_last` transfers. The result does not depend on where idle cycles fall.
- R3: For each reference pixel, the squared distance is dx²+dy²+dz², kept at full precision. The table index is that distance shifted right by `H_SHIFT` (default 6) and saturated at 255.
- R4: Table entry 255 holds weight 0. Entry 0 holds 65535. Each entry k from 1 to 254 equals floor(entry(k-1) × 63520 / 65536).
- R5: At the end of a pass, each new coordinate is floor(Σ weight·coordinate / Σ weight), taken over every pixel transferred in that pass.
- R6: If the weight sum of a pass is zero, the point stays where it is.
- R7: Each pass measures distances from the location produced by the previous pass. The first pass measures from the initial point.
- R8: When every coordinate's absolute change in a pass is at most `thresh`, the run ends with `converged` high.
- R9: The run ends after `max_iter` passes, or after one pass when `max_iter` is 0, even if the threshold test fails. In that case `converged` is low.
- R10: At the end of a run, `done` is high for exactly one cycle and `busy` falls in that same cycle. The result location and `converged` hold steady until the next accepted start.
- R11: A start pulse while `busy` is high is ignored. Reference pixels presented while `ref_ready` is low are not taken and leave the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that loads the initial point and begins a run when idle |
| init_x | input | CW | Initial column |
| init_y | input | CW | Initial row |
| init_z | input | CW | Initial intensity |
| thresh | input | CW | Per-coordinate convergence threshold, latched at start |
| max_iter | input | ITER_W | Pass limit, latched at start (0 means 1) |
| ref_valid | input | 1 | Reference pixel present |
| ref_ready | output | 1 | High while a pass is open |
| ref_x | input | CW | Reference pixel column |
| ref_y | input | CW | Reference pixel row |
| ref_z | input | CW | Reference pixel intensity |
| ref_last | input | 1 | Marks the final pixel of a pass |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| converged | output | 1 | The run ended on the threshold test |
| res_x | output | CW | Current or final column |
| res_y | output | CW | Current or final row |
| res_z | output | CW | Current or final intensity |

## Verification
The point is moved over a tight cluster with one distant outlier. This exercises uneven Gaussian weights and several fed-back passes, so any rounding, kernel or feedback error changes the final location. A point placed far from all data tells the zero-weight hold apart from a division by zero. A single-pixel image separates the exact-quotient case from the weighted case. A run at the top corner of the coordinate range tests quotient width and saturation.

The same cluster is then replayed three more ways: with a stall inserted in the stream, with a stray start pulse mid-run, and with a zero or small pass limit. Each replay must match the plain run or the capped model, which separates flow-control effects and iteration control from the arithmetic.

// File: rtl/ms_pkg.sv
package ms_pkg;

  typedef enum logic [1:0] {S_IDLE, S_PASS, S_DRAIN, S_DIV} mover_state_e;

  // Gaussian decay per table step, as a 16-bit fraction (about exp(-1/32))
  localparam int unsigned KERN_DECAY = 63520;
  localparam int unsigned KERN_FRAC  = 16;

  // Kernel table entry k: peak value decayed k times; last entry is zero
  function automatic int unsigned kern_weight(input int k, input int n_ent, input int ww);
    longint unsigned w;
    if (k >= n_ent - 1) return 0;
    w = (64'd1 << ww) - 64'd1;
    for (int i = 0; i < k; i++) w = (w * KERN_DECAY) >> KERN_FRAC;
    return w[31:0];
  endfunction

endpackage

// File: rtl/ms_dist_stage.sv
module ms_dist_stage #(
  parameter int CW   = 8,
  parameter int D2_W = 2*CW+2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_v,
  input  logic                 in_last,
  input  logic [2:0][CW-1:0]   in_pix,
  input  logic [2:0][CW-1:0]   ctr,
  output logic                 out_v,
  output logic                 out_last,
  output logic [2:0][CW-1:0]   out_pix,
  output logic [D2_W-1:0]      out_d2
);
  localparam int SQ_W = 2*CW;

  logic                v1, last1;
  logic [2:0][CW-1:0]  pix1, ad1, ad_n;
  logic [2:0][SQ_W-1:0] sq;

  for (genvar c = 0; c < 3; c++) begin : g_axis
    logic [SQ_W-1:0] ext_c;
    assign ad_n[c] = (in_pix[c] >= ctr[c]) ? (in_pix[c] - ctr[c]) : (ctr[c] - in_pix[c]);
    assign ext_c   = SQ_W'(ad1[c]);
    assign sq[c]   = ext_c * ext_c;
  end

  // stage 1: absolute differences; stage 2: sum of squares
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; last1 <= 1'b0; pix1 <= '0; ad1 <= '0;
      out_v <= 1'b0; out_last <= 1'b0; out_pix <= '0; out_d2 <= '0;
    end else begin
      v1       <= in_v;
      last1    <= in_v && in_last;
      pix1     <= in_pix;
      ad1      <= ad_n;
      out_v    <= v1;
      out_last <= last1;
      out_pix  <= pix1;
      out_d2   <= D2_W'(sq[0]) + D2_W'(sq[1]) + D2_W'(sq[2]);
    end
  end

  // R3: a pixel equal to the centre yields zero distance two cycles later
  p_zero_dist_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_v && in_pix == ctr) |=> ##1 (out_v && out_d2 == '0));

endmodule

// File: rtl/ms_kernel.sv
module ms_kernel #(
  parameter int CW      = 8,
  parameter int WW      = 16,
  parameter int D2_W    = 2*CW+2,
  parameter int LUT_N   = 256,
  parameter int H_SHIFT = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_v,
  input  logic               in_last,
  input  logic [2:0][CW-1:0] in_pix,
  input  logic [D2_W-1:0]    in_d2,
  output logic               out_v,
  output logic               out_last,
  output logic [2:0][CW-1:0] out_pix,
  output logic [WW-1:0]      out_w
);
  localparam int LUT_AW = $clog2(LUT_N);
  localparam logic [D2_W-1:0] SAT_D2 = D2_W'((LUT_N-1) << H_SHIFT);

  logic [WW-1:0]     rom [LUT_N];
  logic [D2_W-1:0]   scaled;
  logic [LUT_AW-1:0] idx;

  for (genvar k = 0; k < LUT_N; k++) begin : g_rom
    localparam int unsigned KV = ms_pkg::kern_weight(k, LUT_N, WW);
    assign rom[k] = WW'(KV);
  end

  assign scaled = in_d2 >> H_SHIFT;
  assign idx    = (scaled >= D2_W'(LUT_N-1)) ? LUT_AW'(LUT_N-1) : scaled[LUT_AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v <= 1'b0; out_last <= 1'b0; out_pix <= '0; out_w <= '0;
    end else begin
      out_v    <= in_v;
      out_last <= in_last;
      out_pix  <= in_pix;
      out_w    <= rom[idx];
    end
  end

  // R4: distances beyond the table range contribute nothing
  p_far_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_v && in_d2 >= SAT_D2) |=> (out_v && out_w == '0));

endmodule

// File: rtl/ms_accum.sv
module ms_accum #(
  parameter int CW     = 8,
  parameter int WW     = 16,
  parameter int WSUM_W = 32,
  parameter int CSUM_W = 40
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   in_v,
  input  logic                   in_last,
  input  logic [2:0][CW-1:0]     in_pix,
  input  logic [WW-1:0]          in_w,
  output logic [WSUM_W-1:0]      wsum,
  output logic [2:0][CSUM_W-1:0] csum,
  output logic                   last_seen
);
  localparam int P_W = WW + CW;

  logic [2:0][P_W-1:0] prod;

  for (genvar c = 0; c < 3; c++) begin : g_prod
    assign prod[c] = P_W'(in_w) * P_W'(in_pix[c]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsum <= '0; csum <= '0; last_seen <= 1'b0;
    end else if (clr) begin
      wsum <= '0; csum <= '0; last_seen <= 1'b0;
    end else begin
      last_seen <= in_v && in_last;
      if (in_v) begin
        wsum <= wsum + WSUM_W'(in_w);
        for (int c = 0; c < 3; c++) csum[c] <= csum[c] + CSUM_W'(prod[c]);
      end
    end
  end

  // R5: the weight sum never wraps while a pass accumulates
  p_wsum_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (wsum >= $past(wsum)));

endmodule

// File: rtl/ms_divider.sv
module ms_divider #(
  parameter int NUM_W = 40,
  parameter int DEN_W = 32,
  parameter int Q_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [Q_W-1:0]   quo
);
  localparam int CNT_W = $clog2(Q_W+1);

  logic             run_q, done_q, fits;
  logic [CNT_W-1:0] cnt_q, sh;
  logic [NUM_W-1:0] rem_q, den_q, trial;
  logic [Q_W-1:0]   q_q;

  assign sh    = cnt_q - 1'b1;
  assign trial = den_q << sh;
  assign fits  = rem_q >= trial;

  // restoring division, one quotient bit per cycle, MSB first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; done_q <= 1'b0; cnt_q <= '0;
      rem_q <= '0; den_q <= '0; q_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        rem_q <= num;
        den_q <= NUM_W'(den);
        q_q   <= '0;
        cnt_q <= CNT_W'(Q_W);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (fits) rem_q <= rem_q - trial;
        q_q   <= {q_q[Q_W-2:0], fits};
        cnt_q <= sh;
        if (cnt_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign quo  = q_q;

  // R5: the owner never restarts a division in flight
  p_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !run_q);

endmodule

// File: rtl/ms_point_mover.sv
module ms_point_mover #(
  parameter int CW       = 8,
  parameter int WW       = 16,
  parameter int H_SHIFT  = 6,
  parameter int LUT_N    = 256,
  parameter int REF_LOG2 = 16,
  parameter int ITER_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CW-1:0]     init_x,
  input  logic [CW-1:0]     init_y,
  input  logic [CW-1:0]     init_z,
  input  logic [CW-1:0]     thresh,
  input  logic [ITER_W-1:0] max_iter,
  input  logic              ref_valid,
  output logic              ref_ready,
  input  logic [CW-1:0]     ref_x,
  input  logic [CW-1:0]     ref_y,
  input  logic [CW-1:0]     ref_z,
  input  logic              ref_last,
  output logic              busy,
  output logic              done,
  output logic              converged,
  output logic [CW-1:0]     res_x,
  output logic [CW-1:0]     res_y,
  output logic [CW-1:0]     res_z
);
  localparam int D2_W   = 2*CW + 2;
  localparam int WSUM_W = WW + REF_LOG2;
  localparam int CSUM_W = WSUM_W + CW;

  ms_pkg::mover_state_e state_q;

  logic [2:0][CW-1:0]     ref_pix, cur_q, nxt, quo;
  logic [CW-1:0]          thr_q;
  logic [ITER_W-1:0]      cap_q, pass_cnt, pass_nxt, cap_eff;
  logic                   conv_q, done_q, wz_q;
  logic                   accept, acc_clr, div_start, div_fin, all_close;
  logic [2:0]             div_done, close;

  logic                   d_v, d_last, k_v, k_last, acc_last;
  logic [2:0][CW-1:0]     d_pix, k_pix;
  logic [D2_W-1:0]        d_d2;
  logic [WW-1:0]          k_w;
  logic [WSUM_W-1:0]      wsum;
  logic [2:0][CSUM_W-1:0] csum;

  assign ref_pix   = {ref_z, ref_y, ref_x};
  assign ref_ready = (state_q == ms_pkg::S_PASS);
  assign accept    = ref_valid && ref_ready;
  assign acc_clr   = (state_q == ms_pkg::S_IDLE) || (state_q == ms_pkg::S_DIV);
  assign div_start = (state_q == ms_pkg::S_DRAIN) && acc_last;
  assign div_fin   = &div_done;
  assign cap_eff   = (max_iter == '0) ? ITER_W'(1) : max_iter;
  assign pass_nxt  = pass_cnt + 1'b1;

  ms_dist_stage #(.CW(CW), .D2_W(D2_W)) u_dist (
    .clk, .rst_n, .in_v(accept), .in_last(ref_last), .in_pix(ref_pix), .ctr(cur_q),
    .out_v(d_v), .out_last(d_last), .out_pix(d_pix), .out_d2(d_d2));

  ms_kernel #(.CW(CW), .WW(WW), .D2_W(D2_W), .LUT_N(LUT_N), .H_SHIFT(H_SHIFT)) u_kern (
    .clk, .rst_n, .in_v(d_v), .in_last(d_last), .in_pix(d_pix), .in_d2(d_d2),
    .out_v(k_v), .out_last(k_last), .out_pix(k_pix), .out_w(k_w));

  ms_accum #(.CW(CW), .WW(WW), .WSUM_W(WSUM_W), .CSUM_W(CSUM_W)) u_acc (
    .clk, .rst_n, .clr(acc_clr), .in_v(k_v), .in_last(k_last), .in_pix(k_pix), .in_w(k_w),
    .wsum(wsum), .csum(csum), .last_seen(acc_last));

  for (genvar c = 0; c < 3; c++) begin : g_coord
    logic [CW-1:0] dlt;
    ms_divider #(.NUM_W(CSUM_W), .DEN_W(WSUM_W), .Q_W(CW)) u_div (
      .clk, .rst_n, .start(div_start), .num(csum[c]), .den(wsum),
      .done(div_done[c]), .quo(quo[c]));
    assign nxt[c]   = wz_q ? cur_q[c] : quo[c];
    assign dlt      = (nxt[c] >= cur_q[c]) ? (nxt[c] - cur_q[c]) : (cur_q[c] - nxt[c]);
    assign close[c] = (dlt <= thr_q);
  end
  assign all_close = &close;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ms_pkg::S_IDLE;
      cur_q <= '0; thr_q <= '0; cap_q <= ITER_W'(1); pass_cnt <= '0;
      conv_q <= 1'b0; done_q <= 1'b0; wz_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ms_pkg::S_IDLE: if (start) begin
          cur_q    <= {init_z, init_y, init_x};
          thr_q    <= thresh;
          cap_q    <= cap_eff;
          pass_cnt <= '0;
          conv_q   <= 1'b0;
          state_q  <= ms_pkg::S_PASS;
        end
        ms_pkg::S_PASS: if (accept && ref_last) state_q <= ms_pkg::S_DRAIN;
        ms_pkg::S_DRAIN: if (acc_last) begin
          wz_q    <= (wsum == '0);
          state_q <= ms_pkg::S_DIV;
        end
        ms_pkg::S_DIV: if (div_fin) begin
          cur_q    <= nxt;
          pass_cnt <= pass_nxt;
          if (all_close || pass_nxt >= cap_q) begin
            conv_q  <= all_close;
            done_q  <= 1'b1;
            state_q <= ms_pkg::S_IDLE;
          end else begin
            state_q <= ms_pkg::S_PASS;
          end
        end
        default: state_q <= ms_pkg::S_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != ms_pkg::S_IDLE);
  assign done      = done_q;
  assign converged = conv_q;
  assign res_x     = cur_q[0];
  assign res_y     = cur_q[1];
  assign res_z     = cur_q[2];

  // R2: the pass closes right after its last pixel transfers
  p_ready_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && ref_ready && ref_last) |=> !ref_ready);
  // R9: a run never counts past its pass limit
  p_pass_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pass_cnt < cap_q));
  // R10: done is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10: the result holds while idle without a start
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable({res_x, res_y, res_z, converged}));
  // R11: an idle start opens a pass on the next cycle
  p_start_opens_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && ref_ready));

endmodule

// File: tb/ms_point_mover_bench.sv
module ms_point_mover_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] init_x = '0, init_y = '0, init_z = '0, thresh = '0, max_iter = '0;
  logic       ref_valid = 1'b0, ref_last = 1'b0;
  logic [7:0] ref_x = '0, ref_y = '0, ref_z = '0;
  logic       ref_ready, busy, done, converged;
  logic [7:0] res_x, res_y, res_z;

  always #(CLK_PERIOD/2) clk = ~clk;

  ms_point_mover u_ms_point_mover (
    .clk, .rst_n, .start, .init_x, .init_y, .init_z, .thresh, .max_iter,
    .ref_valid, .ref_ready, .ref_x, .ref_y, .ref_z, .ref_last,
    .busy, .done, .converged, .res_x, .res_y, .res_z);

  typedef struct { int x; int y; int z; int conv; string tag; } exp_t;
  exp_t sb[$];

  int checks = 0, errors = 0;
  int kw[256];
  int img_x[16], img_y[16], img_z[16];
  int img_n = 0;
  int last_x = 0, last_y = 0, last_z = 0;

  function automatic int pack3(int a, int b, int c);
    return (a << 16) | (b << 8) | c;
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // reference model built from the requirements
  task automatic model(input int px, input int py, input int pz, input int thr, input int maxit,
                       output int ox, output int oy, output int oz, output int oc);
    int cx, cy, cz, cap, n, nx, ny, nz, k, dx, dy, dz;
    longint sw, sx, sy, sz, d2;
    bit cl;
    cx = px; cy = py; cz = pz; n = 0; oc = 0;
    cap = (maxit == 0) ? 1 : maxit;
    forever begin
      sw = 0; sx = 0; sy = 0; sz = 0;
      for (int i = 0; i < img_n; i++) begin
        dx = img_x[i] - cx; dy = img_y[i] - cy; dz = img_z[i] - cz;
        d2 = longint'(dx*dx + dy*dy + dz*dz);
        k = int'(d2 / 64);
        if (k > 255) k = 255;
        sw += kw[k];
        sx += longint'(kw[k]) * img_x[i];
        sy += longint'(kw[k]) * img_y[i];
        sz += longint'(kw[k]) * img_z[i];
      end
      if (sw == 0) begin nx = cx; ny = cy; nz = cz; end
      else begin nx = int'(sx / sw); ny = int'(sy / sw); nz = int'(sz / sw); end
      cl = ((nx > cx ? nx - cx : cx - nx) <= thr) && ((ny > cy ? ny - cy : cy - ny) <= thr)
        && ((nz > cz ? nz - cz : cz - nz) <= thr);
      cx = nx; cy = ny; cz = nz; n++;
      if (cl) begin oc = 1; break; end
      if (n >= cap) break;
    end
    ox = cx; oy = cy; oz = cz;
  endtask

  task automatic stream_pass(input bit gap, inout bit poke, input string tag);
    bit rdy_ok = 1'b1;
    for (int i = 0; i < img_n; i++) begin
      if (gap && i == 2) begin
        ref_valid = 1'b0;
        @(negedge clk);
        rdy_ok &= ref_ready;
      end
      rdy_ok &= ref_ready;
      ref_valid = 1'b1;
      ref_x = 8'(img_x[i]); ref_y = 8'(img_y[i]); ref_z = 8'(img_z[i]);
      ref_last = (i == img_n - 1);
      if (poke && i == 0) begin
        start = 1'b1; init_x = 8'd7; init_y = 8'd9; init_z = 8'd11;
      end
      @(negedge clk);
      start = 1'b0;
    end
    poke = 1'b0;
    ref_valid = 1'b0; ref_last = 1'b0;
    check(rdy_ok, "R2", "ready held through pass", 0, 1);
    check(!ref_ready, "R2", "ready low after last", int'(ref_ready), 0);
  endtask

  task automatic run_job(input int px, input int py, input int pz, input int thr, input int maxit,
                         input bit gap, input bit poke_in, input string tag);
    exp_t e;
    bit poke;
    poke = poke_in;
    model(px, py, pz, thr, maxit, e.x, e.y, e.z, e.conv);
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    init_x = 8'(px); init_y = 8'(py); init_z = 8'(pz);
    thresh = 8'(thr); max_iter = 8'(maxit);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    forever begin
      if (!busy) break;
      if (ref_ready) stream_pass(gap, poke, tag);
      else @(negedge clk);
    end
  endtask

  // monitor: compares each finished run against the scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      exp_t e;
      if (sb.size() == 0) begin
        check(1'b0, "R10", "done without pending run", 1, 0);
      end else begin
        e = sb.pop_front();
        check(res_x == 8'(e.x) && res_y == 8'(e.y) && res_z == 8'(e.z), e.tag, "location",
              pack3(int'(res_x), int'(res_y), int'(res_z)), pack3(e.x, e.y, e.z));
        check(converged == e.conv[0], e.tag, "converged", int'(converged), e.conv);
        check(!busy, "R10", "busy falls with done", int'(busy), 0);
      end
      last_x = int'(res_x); last_y = int'(res_y); last_z = int'(res_z);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    kw[0] = 65535;
    for (int k = 1; k < 255; k++) kw[k] = int'((longint'(kw[k-1]) * 63520) >>> 16);
    kw[255] = 0;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !ref_ready && !converged, "R1", "control outputs after reset",
          int'({busy, done, ref_ready, converged}), 0);
    check(res_x == 0 && res_y == 0 && res_z == 0, "R1", "location after reset",
          pack3(int'(res_x), int'(res_y), int'(res_z)), 0);

    // image A: tight cluster plus a distant outlier
    img_n = 5;
    img_x[0] = 110; img_y[0] = 105; img_z[0] = 120;
    img_x[1] = 112; img_y[1] = 108; img_z[1] = 118;
    img_x[2] = 108; img_y[2] = 104; img_z[2] = 122;
    img_x[3] = 115; img_y[3] = 110; img_z[3] = 125;
    img_x[4] = 30;  img_y[4] = 200; img_z[4] = 10;

    run_job(100, 100, 100, 1, 20, 1'b0, 1'b0, "R3 R4 R5 R7 R8");
    run_job(0, 0, 0, 3, 20, 1'b0, 1'b0, "R6");
    run_job(80, 90, 95, 0, 2, 1'b0, 1'b0, "R9");
    run_job(80, 90, 95, 0, 0, 1'b0, 1'b0, "R9");
    run_job(100, 100, 100, 1, 20, 1'b1, 1'b0, "R2");
    run_job(100, 100, 100, 1, 20, 1'b0, 1'b1, "R11");

    // pixels offered while idle are not taken and change nothing
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      ref_valid = 1'b1; ref_x = 8'd1; ref_y = 8'd2; ref_z = 8'd3; ref_last = 1'b1;
      @(negedge clk);
      check(!ref_ready && !busy, "R11", "idle ignores stream", int'({ref_ready, busy}), 0);
    end
    ref_valid = 1'b0; ref_last = 1'b0;
    check(int'(res_x) == last_x && int'(res_y) == last_y && int'(res_z) == last_z, "R11",
          "location held while idle", pack3(int'(res_x), int'(res_y), int'(res_z)),
          pack3(last_x, last_y, last_z));

    // image B: top corner of the coordinate range
    img_n = 3;
    img_x[0] = 255; img_y[0] = 255; img_z[0] = 255;
    img_x[1] = 250; img_y[1] = 252; img_z[1] = 255;
    img_x[2] = 255; img_y[2] = 240; img_z[2] = 250;
    run_job(255, 255, 255, 0, 6, 1'b0, 1'b0, "R3 R5");

    // image C: one pixel, exact quotient then zero move
    img_n = 1;
    img_x[0] = 52; img_y[0] = 58; img_z[0] = 75;
    run_job(50, 60, 70, 0, 4, 1'b0, 1'b0, "R5 R7 R8");

    repeat (5) @(negedge clk);
    check(sb.size() == 0, "R10", "every run reported done", sb.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule